// File: doc/BRIEF.md
# UV-Erasable Byte-Wide ROM Pin-Level Model

This block is a synthesizable, pin-level behavioural model of a byte-wide ROM. It is programmed one way and erased with ultraviolet light. The array is scaled down and its depth is a parameter. The model decodes a small set of operating modes from the control pins:

- **read**: the array is driven onto the outputs.
- **output disable**: the part is selected but the outputs are off.
- **standby**: the part is deselected and the outputs are off.
- **program**: a low pulse on chip enable writes a byte.
- **program inhibit**: the programming supply is high but chip enable is held high, so nothing is written.
- **verify**: the array is driven onto the outputs while the programming supply is high.
- **signature**: a two-byte identification code is read back.

Two digital flags stand in for the analog conditions. One flags the programming supply at high voltage. The other flags the identification address pin at high voltage.

Programming can only clear bits. The stored byte becomes the old byte ANDed with the presented byte. The only way to bring bits back to 1 is a one-cycle erase strobe, which takes the place of UV exposure. The block fits a bus-level system model that needs a boot ROM with realistic programming behaviour.

A byte write commits on the first clock edge at which chip enable is seen high again after at least one cycle spent in program mode. Address and data are taken at that edge.

Top module: `uv_eprom`

## Requirements
- R1: With ce_n_i=0, oe_n_i=0, vpp_hi_i=0 and id_hv_i=0, dout_o equals the stored byte at addr_i and every bit of dout_oe_o is 1.
- R2: With ce_n_i=1 and vpp_hi_i=0 (standby), dout_oe_o is all 0 for both values of oe_n_i.
- R3: With ce_n_i=0, oe_n_i=1 and vpp_hi_i=0 (output disable), dout_oe_o is all 0, and a rise of ce_n_i from this state writes nothing.
- R4: After reset, and on the clock edge where erase_i=1, every stored byte becomes all ones (0xFF for the default width).
- R5: With vpp_hi_i=1 and oe_n_i=1, ce_n_i low for at least one clock edge and then high writes at the first edge that sees ce_n_i=1. The byte at addr_i becomes (old AND din_i), using the addr_i and din_i present at that edge.
- R6: A stored bit never goes from 0 to 1 except by erase. A 1 in din_i leaves the stored bit unchanged.
- R7: With vpp_hi_i=1, ce_n_i=1 and oe_n_i=1 (program inhibit), dout_oe_o is all 0 and no byte changes.
- R8: With vpp_hi_i=1 and oe_n_i=0 (verify), dout_o equals the stored byte at addr_i and dout_oe_o is all 1 for either ce_n_i value. A ce_n_i rise in verify writes nothing.
- R9: With id_hv_i=1 in the read condition of R1, dout_o is 0x8F when addr_i[0]=0 and 0x08 when addr_i[0]=1. All other address bits are ignored.
- R10: When erase_i=1 coincides with a write commit, the erase wins and the addressed byte reads all ones afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; leaves the array erased |
| addr_i | input | AW | Byte address, AW = clog2(DEPTH) |
| ce_n_i | input | 1 | Chip enable and program strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| vpp_hi_i | input | 1 | Programming supply at high voltage |
| id_hv_i | input | 1 | Identification address pin at high voltage |
| din_i | input | WIDTH | Byte presented for programming |
| erase_i | input | 1 | Erase strobe; sets every bit to 1 |
| dout_o | output | WIDTH | Output data, 0 when not driven |
| dout_oe_o | output | WIDTH | Per-bit output enable (1 = driven) |

## Verification
The bench reprograms an already written byte with a pattern that contains ones. A design that overwrote the byte instead of ANDing it would read back set bits that should have stayed cleared.

It raises chip enable in output-disable, inhibit and verify states with zero data and then reads the byte. A decoder that treated any chip-enable rise as a program pulse would show a corrupted byte.

The signature check uses addresses whose high bits are all ones, which exposes a decoder that compares the whole address rather than bit 0. An erase issued on the same edge as a commit checks that the erase takes priority.

// File: rtl/eprom_pkg.sv
package eprom_pkg;
  typedef enum logic [2:0] {
    MD_READ    = 3'd0,
    MD_OUT_OFF = 3'd1,
    MD_STANDBY = 3'd2,
    MD_PROG    = 3'd3,
    MD_VERIFY  = 3'd4,
    MD_INHIBIT = 3'd5,
    MD_SIG     = 3'd6
  } mode_e;

  localparam logic [7:0] MFR_CODE = 8'h8F;
  localparam logic [7:0] DEV_CODE = 8'h08;
endpackage

// File: rtl/eprom_mode_dec.sv
module eprom_mode_dec
  import eprom_pkg::*;
(
  input  logic  ce_n_i,
  input  logic  oe_n_i,
  input  logic  vpp_hi_i,
  input  logic  id_hv_i,
  output mode_e mode_o
);
  always_comb begin
    if (vpp_hi_i) begin
      if (!oe_n_i)      mode_o = MD_VERIFY;
      else if (!ce_n_i) mode_o = MD_PROG;
      else              mode_o = MD_INHIBIT;
    end else begin
      if (ce_n_i)       mode_o = MD_STANDBY;
      else if (oe_n_i)  mode_o = MD_OUT_OFF;
      else if (id_hv_i) mode_o = MD_SIG;
      else              mode_o = MD_READ;
    end
  end
endmodule

// File: rtl/eprom_pgm_ctl.sv
module eprom_pgm_ctl
  import eprom_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_e mode_i,
  input  logic  ce_n_i,
  input  logic  oe_n_i,
  input  logic  vpp_hi_i,
  output logic  commit_o
);
  logic in_prog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) in_prog_q <= 1'b0;
    else         in_prog_q <= (mode_i == MD_PROG);
  end

  // pulse ends: previous cycle programming, strobe now high, supply and OE still set
  assign commit_o = in_prog_q & ce_n_i & oe_n_i & vpp_hi_i;

  // R5
  commit_after_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> ($past(ce_n_i) == 1'b0 && $past(vpp_hi_i) && $past(oe_n_i)));

  // R8
  no_commit_in_verify_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && !oe_n_i) |-> !commit_o);
endmodule

// File: rtl/eprom_cell_array.sv
module eprom_cell_array #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_i,
  input  logic             commit_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] rd_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (erase_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (commit_i) begin
      mem_q[addr_i] <= mem_q[addr_i] & din_i;
    end
  end

  assign rd_o = mem_q[addr_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell_chk
    // R6
    ones_only_by_erase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((mem_q[g] & ~$past(mem_q[g])) != '0) |-> $past(erase_i));
    // R4
    erase_sets_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      erase_i |=> (mem_q[g] == '1));
  end
endmodule

// File: rtl/eprom_out_sel.sv
module eprom_out_sel
  import eprom_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e            mode_i,
  input  logic             addr0_i,
  input  logic [WIDTH-1:0] rd_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] dout_oe_o
);
  localparam logic [WIDTH-1:0] MFR_W = WIDTH'(MFR_CODE);
  localparam logic [WIDTH-1:0] DEV_W = WIDTH'(DEV_CODE);

  always_comb begin
    unique case (mode_i)
      MD_READ, MD_VERIFY: begin
        dout_o    = rd_i;
        dout_oe_o = '1;
      end
      MD_SIG: begin
        dout_o    = addr0_i ? DEV_W : MFR_W;
        dout_oe_o = '1;
      end
      default: begin
        dout_o    = '0;
        dout_oe_o = '0;
      end
    endcase
  end
endmodule

// File: rtl/uv_eprom.sv
module uv_eprom
  import eprom_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             ce_n_i,
  input  logic             oe_n_i,
  input  logic             vpp_hi_i,
  input  logic             id_hv_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             erase_i,
  output logic [WIDTH-1:0] dout_o,
  output logic [WIDTH-1:0] dout_oe_o
);
  mode_e            mode;
  logic             commit;
  logic [WIDTH-1:0] rd_data;

  eprom_mode_dec u_dec (
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .vpp_hi_i(vpp_hi_i),
    .id_hv_i (id_hv_i),
    .mode_o  (mode)
  );

  eprom_pgm_ctl u_pgm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .mode_i  (mode),
    .ce_n_i  (ce_n_i),
    .oe_n_i  (oe_n_i),
    .vpp_hi_i(vpp_hi_i),
    .commit_o(commit)
  );

  eprom_cell_array #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .erase_i (erase_i),
    .commit_i(commit),
    .addr_i  (addr_i),
    .din_i   (din_i),
    .rd_o    (rd_data)
  );

  eprom_out_sel #(.WIDTH(WIDTH)) u_out (
    .mode_i   (mode),
    .addr0_i  (addr_i[0]),
    .rd_i     (rd_data),
    .dout_o   (dout_o),
    .dout_oe_o(dout_oe_o)
  );

  // R1
  read_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && !oe_n_i && !vpp_hi_i) |-> (dout_oe_o == '1));
  // R2
  standby_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_i && !vpp_hi_i) |-> (dout_oe_o == '0));
  // R3
  out_off_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && oe_n_i && !vpp_hi_i) |-> (dout_oe_o == '0));
  // R7
  inhibit_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && ce_n_i && oe_n_i) |-> (dout_oe_o == '0));
  // R8
  verify_drives_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vpp_hi_i && !oe_n_i) |-> (dout_oe_o == '1));
  // R9
  sig_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (id_hv_i && !ce_n_i && !oe_n_i && !vpp_hi_i) |->
      (dout_o == (addr_i[0] ? WIDTH'(DEV_CODE) : WIDTH'(MFR_CODE))));
endmodule

// File: tb/tb_uv_eprom.sv
module tb_uv_eprom;
  localparam int DEPTH = 64;
  localparam int WIDTH = 8;
  localparam int AW = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [AW-1:0]    addr = '0;
  logic             ce_n = 1'b1, oe_n = 1'b1, vpp = 1'b0, idhv = 1'b0, erase = 1'b0;
  logic [WIDTH-1:0] din = '0;
  logic [WIDTH-1:0] dout, dout_oe;

  always #2 clk = ~clk;

  uv_eprom #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n),
    .vpp_hi_i(vpp), .id_hv_i(idhv), .din_i(din), .erase_i(erase),
    .dout_o(dout), .dout_oe_o(dout_oe)
  );

  typedef struct {
    logic [WIDTH-1:0] dq;
    logic [WIDTH-1:0] oe;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // monitor: pops every queued expectation at the falling edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dout_oe !== e.oe || (e.oe != '0 && dout !== e.dq)) begin
        fails++;
        $display("FAIL %s: dout=%h oe=%h expected dout=%h oe=%h",
                 e.tag, dout, dout_oe, e.dq, e.oe);
      end
    end
  end

  task automatic drive(input logic c, input logic o, input logic v, input logic s,
                       input logic [AW-1:0] a, input logic [WIDTH-1:0] d, input logic er);
    @(posedge clk); #1;
    ce_n = c; oe_n = o; vpp = v; idhv = s; addr = a; din = d; erase = er;
  endtask

  task automatic expect_out(input logic [WIDTH-1:0] dq, input logic [WIDTH-1:0] oe,
                            input string tag);
    exp_t e;
    e.dq = dq; e.oe = oe; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk); #0.5;
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [WIDTH-1:0] dq, input string tag);
    drive(0, 0, 0, 0, a, '0, 0);
    expect_out(dq, '1, tag);
  endtask

  task automatic pgm(input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    drive(0, 1, 1, 0, a, d, 0);
    drive(1, 1, 1, 0, a, d, 0);
    drive(1, 1, 0, 0, a, '0, 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R4 reset state erased
    rd(0, 8'hFF, "R4 reset addr0");
    rd(DEPTH-1, 8'hFF, "R4 reset last addr");

    // R5 program and read back
    pgm(5, 8'hA5);
    rd(5, 8'hA5, "R5 program A5 at 5");
    rd(4, 8'hFF, "R5 neighbour untouched");
    // R6 ones in data do not restore bits
    pgm(5, 8'hF0);
    rd(5, 8'hA0, "R6 AND with F0");
    pgm(DEPTH-1, 8'h00);
    rd(DEPTH-1, 8'h00, "R5 last address cleared");

    // R2 standby with both OE values
    drive(1, 0, 0, 0, 5, '0, 0);
    expect_out('0, '0, "R2 standby oe low");
    drive(1, 1, 0, 0, 5, '0, 0);
    expect_out('0, '0, "R2 standby oe high");

    // R3 output disable, then a chip-enable rise must not write
    drive(0, 1, 0, 0, 7, 8'h00, 0);
    expect_out('0, '0, "R3 output disable hiz");
    drive(1, 1, 0, 0, 7, 8'h00, 0);
    rd(7, 8'hFF, "R3 no write from disable");

    // R7 inhibit
    drive(1, 1, 1, 0, 8, 8'h00, 0);
    expect_out('0, '0, "R7 inhibit hiz");
    drive(1, 1, 1, 0, 8, 8'h00, 0);
    rd(8, 8'hFF, "R7 no write in inhibit");

    // R8 verify with both CE values and a rise
    drive(0, 0, 1, 0, 5, 8'h00, 0);
    expect_out(8'hA0, '1, "R8 verify ce low");
    drive(1, 0, 1, 0, 5, 8'h00, 0);
    expect_out(8'hA0, '1, "R8 verify ce high");
    rd(5, 8'hA0, "R8 no write from verify");

    // R9 signature
    drive(0, 0, 0, 1, 0, '0, 0);
    expect_out(8'h8F, '1, "R9 mfr code addr0");
    drive(0, 0, 0, 1, 1, '0, 0);
    expect_out(8'h08, '1, "R9 dev code addr1");
    drive(0, 0, 0, 1, AW'(DEPTH-2), '0, 0);
    expect_out(8'h8F, '1, "R9 mfr code high bits set");
    drive(0, 0, 0, 1, AW'(DEPTH-1), '0, 0);
    expect_out(8'h08, '1, "R9 dev code high bits set");

    // R1 plain read after signature
    rd(5, 8'hA0, "R1 read stored byte");

    // R4 erase strobe
    drive(1, 1, 0, 0, 0, '0, 1);
    drive(1, 1, 0, 0, 0, '0, 0);
    rd(5, 8'hFF, "R4 erase addr5");
    rd(DEPTH-1, 8'hFF, "R4 erase last addr");

    // R10 erase wins over a coincident commit
    drive(0, 1, 1, 0, 9, 8'h00, 0);
    drive(1, 1, 1, 0, 9, 8'h00, 1);
    drive(1, 1, 0, 0, 9, 8'h00, 0);
    rd(9, 8'hFF, "R10 erase beats commit");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule